// File: doc/BRIEF.md
# Histogram and Hough Vote Accumulator

This block turns a stream of 9-bit samples into votes in a 512-bin accumulator memory of 24-bit words. The memory sits outside the block, which reaches it through a read port and a write port. A 2-bit operation code picks the meaning of each sample:

- **Histogram:** the sample value itself is the bin to increment.
- **Hough:** the sample indexes one of four 512-entry, 9-bit lookup tables. The table value plus the current row count forms a 10-bit sum, and a shift control picks either its low or its high nine bits as the bin.
- **Pixel location:** the row count is stored in the bin named by the sample.

Every increment is a pipelined read-modify-write that stops at all ones. Samples that follow each other on the same bin are resolved by forwarding, so no vote is lost. A clear sequence zeroes all bins before a frame and holds off input while it runs. The lookup tables are loaded through a separate write port.

Top module: `hh_accum`

## Requirements
- R1: After reset `busy`, `acc_rd_en` and `acc_wr_en` are low.
- R2: `in_ready` is high only when `test_n` is high and `busy` is low; a sample is taken only in a cycle where both `in_valid` and `in_ready` are high, and nothing else reaches the memory.
- R3: With `fn` = 2'b00 (histogram), bin `in_sample` is incremented by one.
- R4: With `fn` = 2'b01 (Hough), sum = table[`lut_sel`][`in_sample`] + `in_ycount` as a 10-bit value; bin sum[8:0] is incremented when `shift_hi` is low, bin sum[9:1] when it is high.
- R5: A cycle with `lut_we` high stores `lut_wdata` in table `lut_wtab` at `lut_waddr`; the other three tables are unchanged.
- R6: With `fn` = 2'b10 (pixel location), bin `in_sample` is written with `in_ycount` zero-extended to 24 bits, without a read.
- R7: With `fn` = 2'b11 the sample is accepted but causes no read and no write.
- R8: An increment of a bin holding 24'hFFFFFF leaves it at 24'hFFFFFF.
- R9: Samples on consecutive cycles that target the same bin, including an increment right after a pixel-location write, give the same contents as if each had completed alone.
- R10: A `clr_start` pulse while not busy raises `busy` on the next cycle; all 512 bins are then written with zero, and `busy` falls afterwards. `in_ready` stays low while busy, so samples presented during the clear are not taken.
- R11: For an increment accepted at clock edge t, `acc_rd_en` with the bin address is high in the cycle after t. The memory returns the word (old contents on a same-cycle write) one cycle later, and `acc_wr_en` with the new value is high in that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_start | input | 1 | Start a clear of all bins |
| busy | output | 1 | Clear in progress |
| test_n | input | 1 | High for normal operation; low blocks input |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be taken |
| in_sample | input | 9 | Sample value |
| in_ycount | input | 9 | Current row count |
| fn | input | 2 | Operation code |
| lut_sel | input | 2 | Active lookup table |
| shift_hi | input | 1 | Use the high nine bits of the Hough sum |
| lut_we | input | 1 | Lookup table write strobe |
| lut_wtab | input | 2 | Table to write |
| lut_waddr | input | 9 | Table entry to write |
| lut_wdata | input | 9 | Value to write |
| acc_rd_en | output | 1 | Accumulator read request |
| acc_rd_addr | output | 9 | Accumulator read bin |
| acc_rd_data | input | 24 | Accumulator read word, one cycle after request |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_addr | output | 9 | Accumulator write bin |
| acc_wr_data | output | 24 | Accumulator write word |

## Verification
The hardest case is a same-bin collision. It arises when one sample's read happens on the same edge as the previous sample's write-back to that bin, so the memory returns stale data. From the ports this takes samples on consecutive cycles that map to one bin. The bench drives runs of repeated histogram values, a pixel-location write followed at once by increments of the same bin, and Hough sequences whose table values and row counts collide. It then compares every bin with its own vote model.

// File: rtl/hh_pkg.sv
package hh_pkg;
    localparam int unsigned SAMPLE_W = 9;
    localparam int unsigned ACC_W    = 24;
    localparam int unsigned NUM_TAB  = 4;
    localparam int unsigned TAB_W    = $clog2(NUM_TAB);
    localparam int unsigned DEPTH    = 1 << SAMPLE_W;

    typedef enum logic [1:0] {
        FN_HIST  = 2'b00,
        FN_HOUGH = 2'b01,
        FN_PIXEL = 2'b10,
        FN_UNDEF = 2'b11
    } fn_e;

    typedef enum logic {
        OP_INC = 1'b0,
        OP_SET = 1'b1
    } op_e;

    typedef struct packed {
        logic                v;
        op_e                 op;
        logic [SAMPLE_W-1:0] addr;
        logic [SAMPLE_W-1:0] ydat;
    } stage_t;

    typedef struct packed {
        stage_t              s1;
        stage_t              s2;
        logic                fwd_v;
        logic [ACC_W-1:0]    fwd_data;
        logic                busy;
        logic [SAMPLE_W-1:0] clr_cnt;
    } state_t;
endpackage

// File: rtl/hh_lut_bank.sv
module hh_lut_bank #(
    parameter int unsigned W  = 9,
    parameter int unsigned NT = 4
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [$clog2(NT)-1:0] wtab,
    input  logic [W-1:0]          waddr,
    input  logic [W-1:0]          wdata,
    input  logic [$clog2(NT)-1:0] rsel,
    input  logic [W-1:0]          raddr,
    output logic [W-1:0]          rdata
);
    localparam int unsigned TW = $clog2(NT);
    localparam int unsigned D  = 1 << W;

    logic [W-1:0] rd_each [NT];

    for (genvar t = 0; t < NT; t++) begin : g_tab
        logic [W-1:0] mem [D];
        always_ff @(posedge clk) begin
            if (we && wtab == TW'(t)) begin
                mem[waddr] <= wdata;
            end
        end
        assign rd_each[t] = mem[raddr];
    end

    assign rdata = rd_each[rsel];
endmodule

// File: rtl/hh_addr_gen.sv
module hh_addr_gen #(
    parameter int unsigned W = 9
) (
    input  logic [1:0]   fn,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] ycount,
    input  logic [W-1:0] lut_val,
    input  logic         shift_hi,
    output logic [W-1:0] addr
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, lut_val} + {1'b0, ycount};
        if (fn == hh_pkg::FN_HOUGH) begin
            addr = shift_hi ? sum[W:1] : sum[W-1:0];
        end else begin
            addr = sample;
        end
    end
endmodule

// File: rtl/hh_sat_inc.sv
module hh_sat_inc #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] in_val,
    output logic [W-1:0] out_val
);
    always_comb begin
        out_val = (&in_val) ? in_val : in_val + W'(1);
    end
endmodule

// File: rtl/hh_accum.sv
module hh_accum
    import hh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_start,
    output logic                busy,
    input  logic                test_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [SAMPLE_W-1:0] in_ycount,
    input  logic [1:0]          fn,
    input  logic [TAB_W-1:0]    lut_sel,
    input  logic                shift_hi,
    input  logic                lut_we,
    input  logic [TAB_W-1:0]    lut_wtab,
    input  logic [SAMPLE_W-1:0] lut_waddr,
    input  logic [SAMPLE_W-1:0] lut_wdata,
    output logic                acc_rd_en,
    output logic [SAMPLE_W-1:0] acc_rd_addr,
    input  logic [ACC_W-1:0]    acc_rd_data,
    output logic                acc_wr_en,
    output logic [SAMPLE_W-1:0] acc_wr_addr,
    output logic [ACC_W-1:0]    acc_wr_data
);
    state_t q, d;

    logic [SAMPLE_W-1:0] lut_val;
    logic [SAMPLE_W-1:0] vote_addr;
    logic [ACC_W-1:0]    old_val;
    logic [ACC_W-1:0]    inc_val;
    logic [ACC_W-1:0]    s2_wdata;
    logic                accept;

    hh_lut_bank #(.W(SAMPLE_W), .NT(NUM_TAB)) u_lut (
        .clk   (clk),
        .we    (lut_we),
        .wtab  (lut_wtab),
        .waddr (lut_waddr),
        .wdata (lut_wdata),
        .rsel  (lut_sel),
        .raddr (in_sample),
        .rdata (lut_val)
    );

    hh_addr_gen #(.W(SAMPLE_W)) u_addr (
        .fn       (fn),
        .sample   (in_sample),
        .ycount   (in_ycount),
        .lut_val  (lut_val),
        .shift_hi (shift_hi),
        .addr     (vote_addr)
    );

    // Forwarded word replaces the memory word when the previous write hit the same bin
    assign old_val = q.fwd_v ? q.fwd_data : acc_rd_data;

    hh_sat_inc #(.W(ACC_W)) u_inc (
        .in_val  (old_val),
        .out_val (inc_val)
    );

    always_comb begin
        d           = q;
        in_ready    = test_n && !q.busy;
        accept      = in_valid && in_ready;
        acc_rd_en   = 1'b0;
        acc_rd_addr = q.s1.addr;
        acc_wr_en   = 1'b0;
        acc_wr_addr = q.s2.addr;
        acc_wr_data = '0;
        s2_wdata    = (q.s2.op == OP_SET) ? ACC_W'(q.s2.ydat) : inc_val;

        // stage 1: capture the accepted vote
        d.s1 = '0;
        if (accept && fn_e'(fn) != FN_UNDEF) begin
            d.s1.v    = 1'b1;
            d.s1.op   = (fn_e'(fn) == FN_PIXEL) ? OP_SET : OP_INC;
            d.s1.addr = vote_addr;
            d.s1.ydat = in_ycount;
        end

        // stage 1 issues the read, stage 2 writes back
        acc_rd_en = q.s1.v && q.s1.op == OP_INC;
        d.s2      = q.s1;
        if (q.s2.v) begin
            acc_wr_en   = 1'b1;
            acc_wr_data = s2_wdata;
        end
        d.fwd_v    = q.s1.v && q.s2.v && q.s1.addr == q.s2.addr;
        d.fwd_data = s2_wdata;

        // clear sequencer, waits for the pipeline to drain
        if (!q.busy) begin
            if (clr_start) begin
                d.busy    = 1'b1;
                d.clr_cnt = '0;
            end
        end else if (!q.s1.v && !q.s2.v) begin
            acc_wr_en   = 1'b1;
            acc_wr_addr = q.clr_cnt;
            acc_wr_data = '0;
            d.clr_cnt   = q.clr_cnt + SAMPLE_W'(1);
            if (q.clr_cnt == SAMPLE_W'(DEPTH - 1)) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_en |=> acc_wr_en); // R11
    AST_NOT_READY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !acc_rd_en); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(clr_start)); // R10
    AST_UNDEF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fn == 2'b11) |=> !acc_rd_en); // R7
    AST_PIXEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fn == 2'b10) |=> !acc_rd_en); // R6
    AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_en && q.s2.v && q.s2.op == OP_INC) |-> acc_wr_data != '0); // R8
endmodule

// File: tb/tb_hh_accum.sv
module tb_hh_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_start = 1'b0;
    logic        busy;
    logic        test_n = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_sample = '0;
    logic [8:0]  in_ycount = '0;
    logic [1:0]  fn = 2'b00;
    logic [1:0]  lut_sel = 2'b00;
    logic        shift_hi = 1'b0;
    logic        lut_we = 1'b0;
    logic [1:0]  lut_wtab = '0;
    logic [8:0]  lut_waddr = '0;
    logic [8:0]  lut_wdata = '0;
    logic        acc_rd_en;
    logic [8:0]  acc_rd_addr;
    logic [23:0] acc_rd_data = '0;
    logic        acc_wr_en;
    logic [8:0]  acc_wr_addr;
    logic [23:0] acc_wr_data;

    int checks = 0;
    int failures = 0;

    logic [23:0] mem [512];
    logic [23:0] expv [512];
    logic [8:0]  lut_m [4][512];

    always #2 clk = ~clk;

    hh_accum dut (
        .clk(clk), .rst_n(rst_n), .clr_start(clr_start), .busy(busy),
        .test_n(test_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .in_ycount(in_ycount), .fn(fn),
        .lut_sel(lut_sel), .shift_hi(shift_hi), .lut_we(lut_we),
        .lut_wtab(lut_wtab), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
        .acc_rd_en(acc_rd_en), .acc_rd_addr(acc_rd_addr), .acc_rd_data(acc_rd_data),
        .acc_wr_en(acc_wr_en), .acc_wr_addr(acc_wr_addr), .acc_wr_data(acc_wr_data)
    );

    // accumulator memory: registered read, returns old contents on collision
    always @(posedge clk) begin
        if (acc_rd_en) acc_rd_data <= mem[acc_rd_addr];
        if (acc_wr_en) mem[acc_wr_addr] <= acc_wr_data;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        checks++;
        for (int i = 0; i < 512; i++) begin
            if (mem[i] !== expv[i]) begin
                if (bad < 4)
                    $display("FAIL %s bin %0d actual=%h expected=%h", req, i, mem[i], expv[i]);
                bad++;
            end
        end
        if (bad > 0) failures++;
    endtask

    function automatic logic [8:0] model_addr(input logic [1:0] f, input logic [8:0] s,
                                              input logic [8:0] y, input logic [1:0] t,
                                              input logic sh);
        logic [9:0] sum;
        sum = {1'b0, lut_m[t][s]} + {1'b0, y};
        if (f == 2'b01) return sh ? sum[9:1] : sum[8:0];
        return s;
    endfunction

    // drive one sample for one cycle and update the vote model
    task automatic send(input logic [8:0] s, input logic [8:0] y, input logic [1:0] f,
                        input logic [1:0] t, input logic sh);
        logic [8:0] a;
        @(negedge clk);
        in_valid = 1'b1; in_sample = s; in_ycount = y; fn = f; lut_sel = t; shift_hi = sh;
        a = model_addr(f, s, y, t, sh);
        if (f == 2'b00 || f == 2'b01) begin
            if (expv[a] != 24'hFFFFFF) expv[a] = expv[a] + 24'd1;
        end else if (f == 2'b10) begin
            expv[a] = {15'd0, y};
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic lut_write(input logic [1:0] t, input logic [8:0] a, input logic [8:0] v);
        @(negedge clk);
        lut_we = 1'b1; lut_wtab = t; lut_waddr = a; lut_wdata = v;
        lut_m[t][a] = v;
    endtask

    task automatic test_reset();
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 rd_en", 32'(acc_rd_en), 32'd0);
        check("R1 wr_en", 32'(acc_wr_en), 32'd0);
        check("R2 ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic test_clear();
        int n = 0;
        @(negedge clk);
        clr_start = 1'b1;
        @(negedge clk);
        clr_start = 1'b0;
        check("R10 busy raised", 32'(busy), 32'd1);
        check("R10 ready low while busy", 32'(in_ready), 32'd0);
        in_valid = 1'b1; in_sample = 9'd9; fn = 2'b00;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        for (int i = 0; i < 512; i++) expv[i] = '0;
        check("R10 clear length", 32'(n >= 511 && n < 520), 32'd1);
        repeat (4) @(negedge clk);
        check_mem("R10 all bins zero");
    endtask

    task automatic test_port_timing();
        send(9'd77, 9'd0, 2'b00, 2'd0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 read request", {22'd0, acc_rd_en, acc_rd_addr}, {22'd0, 1'b1, 9'd77});
        @(negedge clk);
        check("R11 write back", {22'd0, acc_wr_en, acc_wr_addr}, {22'd0, 1'b1, 9'd77});
        check("R11 write data", 32'(acc_wr_data), 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_histogram();
        send(9'd3, 0, 2'b00, 0, 0);
        send(9'd3, 0, 2'b00, 0, 0);
        send(9'd3, 0, 2'b00, 0, 0);
        send(9'd7, 0, 2'b00, 0, 0);
        send(9'd3, 0, 2'b00, 0, 0);
        send(9'd7, 0, 2'b00, 0, 0);
        send(9'd7, 0, 2'b00, 0, 0);
        send(9'd511, 0, 2'b00, 0, 0);
        send(9'd0, 0, 2'b00, 0, 0);
        send(9'd511, 0, 2'b00, 0, 0);
        drain();
        check_mem("R3 R9 histogram bins");
    endtask

    task automatic test_hough();
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 512; i++)
                lut_write(2'(t), 9'(i), 9'((i * 37 + t * 101 + 13) % 512));
        @(negedge clk);
        lut_we = 1'b0;
        for (int k = 0; k < 48; k++)
            send(9'((k * 53) % 512), 9'((k * 29 + 400) % 512), 2'b01, 2'(k % 4), k[2]);
        for (int k = 0; k < 6; k++)
            send(9'd15, 9'd500, 2'b01, 2'd1, 1'b1);
        drain();
        check_mem("R4 R9 hough bins");
        lut_write(2'd2, 9'd10, 9'd500);
        @(negedge clk);
        lut_we = 1'b0;
        send(9'd10, 9'd100, 2'b01, 2'd2, 1'b0);
        send(9'd10, 9'd100, 2'b01, 2'd1, 1'b0);
        send(9'd10, 9'd100, 2'b01, 2'd3, 1'b1);
        drain();
        check_mem("R5 table write isolation");
    endtask

    task automatic test_pixel();
        send(9'd20, 9'd123, 2'b10, 0, 0);
        send(9'd20, 9'd0, 2'b00, 0, 0);
        send(9'd20, 9'd0, 2'b00, 0, 0);
        send(9'd21, 9'd7, 2'b10, 0, 0);
        send(9'd21, 9'd300, 2'b10, 0, 0);
        drain();
        check_mem("R6 R9 pixel location");
    endtask

    task automatic test_undef();
        send(9'd3, 9'd5, 2'b11, 0, 0);
        send(9'd4, 9'd5, 2'b11, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 no read", 32'(acc_rd_en), 32'd0);
        repeat (4) @(negedge clk);
        check_mem("R7 undefined code leaves bins");
    endtask

    task automatic test_test_low();
        @(negedge clk);
        test_n = 1'b0;
        in_valid = 1'b1; in_sample = 9'd30; fn = 2'b00;
        @(negedge clk);
        check("R2 ready low when test low", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        test_n = 1'b1;
        repeat (4) @(negedge clk);
        check_mem("R2 no sample taken");
    endtask

    task automatic test_saturate();
        @(negedge clk);
        mem[40] = 24'hFFFFFE; expv[40] = 24'hFFFFFE;
        mem[41] = 24'hFFFFFF; expv[41] = 24'hFFFFFF;
        send(9'd40, 0, 2'b00, 0, 0);
        send(9'd40, 0, 2'b00, 0, 0);
        send(9'd40, 0, 2'b00, 0, 0);
        send(9'd41, 0, 2'b00, 0, 0);
        drain();
        check("R8 saturate from below", 32'(mem[40]), 32'hFFFFFF);
        check("R8 saturate held", 32'(mem[41]), 32'hFFFFFF);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 24'd5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_clear();
        test_port_timing();
        test_histogram();
        test_hough();
        test_pixel();
        test_undef();
        test_test_low();
        test_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule